// File: doc/BRIEF.md
# Supply Threshold Edge Event Unit

This unit sits between a supply-voltage comparator and the interrupt and event fabric of a chip. The comparator raises a "below threshold" bit that is asynchronous to the system clock. The unit resynchronizes that bit and watches it for transitions. It turns the transitions that software has selected into sticky pending flags, a level interrupt and single-cycle event pulses. It also holds the 3-bit threshold code and drives it, unchanged, to the analog side. Codes 0 to 6 pick fixed trip points that run from 2.0 V to 2.9 V. Code 7 compares against an external analog input.

Software reaches the unit over a small synchronous read/write register bus that has a combinational read path. There are three registers:
- A control register holds the threshold code, the detector enable and the read-only status bit.
- A mode register holds four independent masks: rising edge, falling edge, interrupt and event.
- A pending register holds the rising and falling flags. Each flag is cleared by writing 1 to its bit.

Each write to the mode register first clears every mask for one cycle and then loads the requested masks. An edge never sees a mix of old and new masks.

Top module: `vdet_edge_unit`

## Requirements
- R1: After reset the threshold code, enable, all four masks, both pending flags, `irqOut` and `evtPulse` are 0. Reads of control (address 0), mode (address 1) and pending (address 2) return 0.
- R2: A write to control stores bits [2:0] as the threshold code and bit 3 as the enable. After the write edge, `levelSel` carries the code unchanged, and reading control returns both fields in the same bit positions.
- R3: Control bit 4 reads the below-threshold status after two synchronizer flops. A change on `cmpBelow` is visible after the second rising clock edge. The bit reads 0 while the enable is 0.
- R4: A 0-to-1 transition of the synchronized status, with the rise mask (mode bit 0) set, sets pending bit 0. A 1-to-0 transition, with the fall mask (mode bit 1) set, sets pending bit 1. Each flag is set one clock edge after the transition reaches the second synchronizer flop.
- R5: A transition whose edge mask is 0 sets no flag and produces no event pulse.
- R6: `irqOut` is high exactly while the interrupt mask (mode bit 2) is 1 and at least one pending flag is set.
- R7: With the event mask (mode bit 3) set, every detected edge produces a one-cycle `evtPulse`. The pulse comes in the same cycle that the flag is set, and it does not depend on the interrupt mask.
- R8: Writing the pending register with bit 0 and/or bit 1 set clears only the flags whose bits are 1. Writing 0 to a bit leaves that flag unchanged.
- R9: If a flag's edge and a write-1 clear of the same flag fall on the same clock edge, the flag stays set.
- R10: After a mode write, the mode register reads 0 for one cycle and then holds the written value. An edge captured in that cycle sets no flag and produces no pulse.
- R11: While the enable is 0, transitions set no flags and produce no pulses. Turning the enable back on while the status is steady does not create a spurious edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpBelow | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational on busAddr |
| levelSel | output | LEVEL_W | Threshold code to the analog side |
| irqOut | output | 1 | Level interrupt request |
| evtPulse | output | 1 | Single-cycle event request |

## Verification
Most internal errors in this unit show up at the ports within three clock edges of a comparator change:
- A wrong synchronizer depth or a stale previous-level register shifts a pending flag, or the event pulse, by a cycle, or makes it disappear.
- A lost mask shows up as a missing or extra `irqOut` or `evtPulse`.

Two faults show only in narrow windows:
- A wrong blanking sequence shows up only in the cycle right after a mode write, as a nonzero readback or a flag caught in that cycle.
- A wrong pending-flag priority shows up only when a clear and a new edge fall on the same clock edge.

The tests aim at exactly those cycles.

// File: rtl/vdet_pkg.sv
package vdet_pkg;

  // Mode masks; the packed order matches mode register bits [3:0]
  typedef struct packed {
    logic evtEn;
    logic irqEn;
    logic fallEn;
    logic riseEn;
  } modeMask_t;

  // Clear strobes from the control to the datapath
  typedef struct packed {
    logic clrFall;
    logic clrRise;
  } pendStrobe_t;

  localparam int MASK_W = $bits(modeMask_t);
  localparam int PEND_W = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_PEND = 2'd2;

endpackage

// File: rtl/vdet_ctrl.sv
module vdet_ctrl
  import vdet_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int LEVEL_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic                statusBit,
  input  logic [PEND_W-1:0]   pendFlags,
  output logic [LEVEL_W-1:0]  levelSel,
  output logic                detEnable,
  output modeMask_t           masks,
  output pendStrobe_t         strobes
);

  localparam int EN_BIT   = LEVEL_W;
  localparam int STAT_BIT = LEVEL_W + 1;

  logic      wrCtrl, wrMode, wrPend;
  logic      blankPhase;
  modeMask_t stagedMask;

  assign wrCtrl = busSel && busWr && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrMode = busSel && busWr && (busAddr == ADDR_W'(ADDR_MODE));
  assign wrPend = busSel && busWr && (busAddr == ADDR_W'(ADDR_PEND));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelSel   <= '0;
      detEnable  <= 1'b0;
      masks      <= '0;
      stagedMask <= '0;
      blankPhase <= 1'b0;
    end else begin
      if (wrCtrl) begin
        levelSel  <= busWdata[LEVEL_W-1:0];
        detEnable <= busWdata[EN_BIT];
      end
      if (wrMode) begin
        // drop every mask first, apply the request one cycle later
        masks      <= '0;
        stagedMask <= modeMask_t'(busWdata[MASK_W-1:0]);
        blankPhase <= 1'b1;
      end else if (blankPhase) begin
        masks      <= stagedMask;
        blankPhase <= 1'b0;
      end
    end
  end

  assign strobes.clrRise = wrPend && busWdata[0];
  assign strobes.clrFall = wrPend && busWdata[1];

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(ADDR_CTRL): begin
        busRdata[LEVEL_W-1:0] = levelSel;
        busRdata[EN_BIT]      = detEnable;
        busRdata[STAT_BIT]    = statusBit;
      end
      ADDR_W'(ADDR_MODE): busRdata[MASK_W-1:0] = masks;
      ADDR_W'(ADDR_PEND): busRdata[PEND_W-1:0] = pendFlags;
      default:            busRdata = '0;
    endcase
  end

endmodule

// File: rtl/vdet_datapath.sv
module vdet_datapath
  import vdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpBelow,
  input  logic              detEnable,
  input  modeMask_t         masks,
  input  pendStrobe_t       strobes,
  output logic              statusBit,
  output logic [PEND_W-1:0] pendFlags,
  output logic              irqOut,
  output logic              evtPulse
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   syncLvl, prevLvl;
  logic [PEND_W-1:0]      hitVec, clrVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], cmpBelow};
      prevLvl <= syncLvl;
    end
  end

  assign syncLvl   = syncReg[SYNC_MSB];
  assign statusBit = detEnable && syncLvl;

  assign hitVec[0] = detEnable && masks.riseEn && syncLvl && !prevLvl;
  assign hitVec[1] = detEnable && masks.fallEn && !syncLvl && prevLvl;
  assign clrVec[0] = strobes.clrRise;
  assign clrVec[1] = strobes.clrFall;

  for (genvar i = 0; i < PEND_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) pendFlags[i] <= 1'b0;
      else       pendFlags[i] <= (pendFlags[i] && !clrVec[i]) || hitVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) evtPulse <= 1'b0;
    else       evtPulse <= masks.evtEn && (|hitVec);
  end

  assign irqOut = masks.irqEn && (|pendFlags);

endmodule

// File: rtl/vdet_edge_unit.sv
module vdet_edge_unit
  import vdet_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int LEVEL_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmpBelow,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [LEVEL_W-1:0] levelSel,
  output logic               irqOut,
  output logic               evtPulse
);

  modeMask_t         modeMask;
  pendStrobe_t       pendStrb;
  logic              detEnable;
  logic              statusBit;
  logic [PEND_W-1:0] pendFlags;

  vdet_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .statusBit(statusBit), .pendFlags(pendFlags),
    .levelSel(levelSel), .detEnable(detEnable),
    .masks(modeMask), .strobes(pendStrb)
  );

  vdet_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .cmpBelow(cmpBelow),
    .detEnable(detEnable), .masks(modeMask), .strobes(pendStrb),
    .statusBit(statusBit), .pendFlags(pendFlags),
    .irqOut(irqOut), .evtPulse(evtPulse)
  );

endmodule

// File: rtl/vdet_edge_chk.sv
module vdet_edge_chk
  import vdet_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              irqOut,
  input logic              evtPulse,
  input logic [PEND_W-1:0] pendFlags,
  input modeMask_t         masks,
  input logic              detEnable,
  input pendStrobe_t       strobes
);

  a_r4_rise_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFlags[0]) |-> $past(masks.riseEn && detEnable));

  a_r4_fall_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFlags[1]) |-> $past(masks.fallEn && detEnable));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !masks.irqEn |-> !irqOut);

  a_r7_evt_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> $past(masks.evtEn && detEnable));

  a_r8_rise_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendFlags[0]) |-> $past(strobes.clrRise));

  a_r8_fall_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendFlags[1]) |-> $past(strobes.clrFall));

  a_r10_blank_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(busSel && busWr && (busAddr == ADDR_W'(ADDR_MODE))) |-> (masks == '0));

endmodule

bind vdet_edge_unit vdet_edge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .irqOut(irqOut), .evtPulse(evtPulse), .pendFlags(pendFlags),
  .masks(modeMask), .detEnable(detEnable), .strobes(pendStrb)
);

// File: tb/tb_vdet_edge_unit.sv
module tb_vdet_edge_unit;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int LEVEL_W = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmpBelow = 1'b0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [LEVEL_W-1:0] levelSel;
  logic              irqOut, evtPulse;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  vdet_edge_unit dut (
    .clk(clk), .rstN(rstN), .cmpBelow(cmpBelow),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .levelSel(levelSel), .irqOut(irqOut), .evtPulse(evtPulse)
  );

  // each vector: mode, comparator level, expected pending, event, irq
  typedef struct packed {
    logic [3:0] mode;
    logic       cmp;
    logic [1:0] expPend;
    logic       expEvt;
    logic       expIrq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'hD, 1'b1, 2'b01, 1'b1, 1'b1},
    '{4'hD, 1'b0, 2'b00, 1'b0, 1'b0},
    '{4'h6, 1'b1, 2'b00, 1'b0, 1'b0},
    '{4'h6, 1'b0, 2'b10, 1'b0, 1'b1},
    '{4'hA, 1'b1, 2'b00, 1'b0, 1'b0},
    '{4'hA, 1'b0, 2'b10, 1'b1, 1'b0},
    '{4'h3, 1'b1, 2'b01, 1'b0, 1'b0},
    '{4'h7, 1'b0, 2'b10, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd0, rd); check("R1 ctrl", rd, 0);
    busRead(2'd1, rd); check("R1 mode", rd, 0);
    busRead(2'd2, rd); check("R1 pend", rd, 0);
    check("R1 levelSel", levelSel, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 evtPulse", evtPulse, 0);

    // R2 level code and enable
    busWrite(2'd0, 8'h0D);
    check("R2 levelSel", levelSel, 5);
    busRead(2'd0, rd); check("R2 ctrl readback", rd, 8'h0D);

    // R3 status through the synchronizer
    @(negedge clk); cmpBelow = 1'b1;
    @(posedge clk); @(negedge clk);
    busRead(2'd0, rd); check("R3 status one edge", rd[4], 0);
    @(posedge clk); @(negedge clk);
    busRead(2'd0, rd); check("R3 status two edges", rd[4], 1);
    busWrite(2'd0, 8'h05);
    busRead(2'd0, rd); check("R3 status disabled", rd[4], 0);
    busWrite(2'd0, 8'h0D);
    @(negedge clk); cmpBelow = 1'b0;
    waitEdges(3);

    // R4 R5 R6 R7 vector table
    for (int i = 0; i < 8; i++) begin
      busWrite(2'd1, {4'h0, VECS[i].mode});
      @(posedge clk); @(negedge clk);
      cmpBelow = VECS[i].cmp;
      waitEdges(3);
      busRead(2'd2, rd);
      check($sformatf("R4/R5 pend vec%0d", i), rd, {6'd0, VECS[i].expPend});
      check($sformatf("R7 evt vec%0d", i), evtPulse, VECS[i].expEvt);
      check($sformatf("R6 irq vec%0d", i), irqOut, VECS[i].expIrq);
      busWrite(2'd2, 8'h03);
    end

    // R8 individual clear
    busWrite(2'd1, 8'h03);
    @(negedge clk); cmpBelow = 1'b1; waitEdges(3);
    cmpBelow = 1'b0; waitEdges(3);
    busRead(2'd2, rd); check("R8 both set", rd, 3);
    busWrite(2'd2, 8'h01);
    busRead(2'd2, rd); check("R8 clear rise only", rd, 2);
    busWrite(2'd2, 8'h02);
    busRead(2'd2, rd); check("R8 clear fall", rd, 0);

    // R9 clear and edge on the same clock edge
    @(negedge clk); cmpBelow = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk);
    busWrite(2'd2, 8'h01);
    busRead(2'd2, rd); check("R9 set wins", rd, 1);
    busWrite(2'd2, 8'h03);

    // R10 mask blanking after a mode write
    @(negedge clk); cmpBelow = 1'b0;
    @(posedge clk);
    busWrite(2'd1, 8'h03);
    busRead(2'd1, rd); check("R10 mode blank", rd, 0);
    @(posedge clk); @(negedge clk);
    busRead(2'd1, rd); check("R10 mode loaded", rd, 3);
    busRead(2'd2, rd); check("R10 edge in blank", rd, 0);
    check("R10 no event", evtPulse, 0);

    // R11 disabled detector
    busWrite(2'd1, 8'h0B);
    busWrite(2'd0, 8'h05);
    @(negedge clk); cmpBelow = 1'b1; waitEdges(3);
    busRead(2'd2, rd); check("R11 rise disabled", rd, 0);
    cmpBelow = 1'b0; waitEdges(3);
    busRead(2'd2, rd); check("R11 fall disabled", rd, 0);
    busWrite(2'd0, 8'h0D);
    waitEdges(3);
    busRead(2'd2, rd); check("R11 reenable quiet", rd, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule